// File: doc/BRIEF.md
# Raster Timing Generator with Border Framing

This block produces the raster position for a video output: a horizontal pixel counter, a vertical line counter, horizontal and vertical sync pulses, and two region flags. The picture is framed by a border that has its own start and stop on each axis, and inside that frame a display window opens at programmable start coordinates. A downstream pixel path uses `win_active` and `win_row` to fetch and show image data. It uses `border_active` to substitute a fixed border colour.

Interlaced scanning, doublescan and blanking are chosen at run time. In interlaced mode the field indicator alternates every field. The long field runs one line more than the short one, and each field has its own vertical window start. Doublescan repeats every source row on two raster lines. Blank stretches the border over the whole raster. A one-cycle field event marks the first clock of each new field, so software can retune the mode during retrace.

All mode inputs act as a shadow set. While the block runs, they are copied into the working set only at the field boundary, so a change never splits a frame. While display enable is low the counters rest at zero, all outputs are quiet and the working set follows the inputs directly.

Top module: `rtg_raster_top`

## Requirements
- R1: The horizontal counter counts 0 up to line total minus one and then wraps to 0. The vertical counter advances on each horizontal wrap. A non-interlaced field lasts field-total lines. `cfg_totals` holds the field total in bits [2*CW-1:CW] and the line total in bits [CW-1:0].
- R2: `hsync` is high during the first HSYNC_W clocks of every line, and `vsync` is high during the first VSYNC_L lines of every field. Both are active high with the default polarity.
- R3: `border_active` is high whenever the position lies outside [start, stop) on either axis. `cfg_hborder` and `cfg_vborder` each hold the start in the upper half and the stop in the lower half.
- R4: `win_active` is high when h is at or above both `cfg_hwin` and the horizontal border start, and below the horizontal border stop. The vertical axis follows the same rule with the current field's window start. `win_row` then equals v minus that start; otherwise it is 0. The region inside the border but before the window start raises neither flag.
- R5: With `cfg_blank` set, `border_active` covers the whole raster and `win_active` stays low.
- R6: With `cfg_interlace` set, `field_odd` toggles at every field end. Field 0 (long) lasts field total plus one lines, and field 1 (short) lasts field-total lines. Field 0 uses the window start in `cfg_vwin` bits [2*CW-1:CW], and field 1 uses bits [CW-1:0].
- R7: With `cfg_dblscan` set, `win_row` equals (v minus the window start) shifted right by one, so each row appears on two lines.
- R8: While running, changes on the configuration inputs take effect only at the first clock of the next field. While `disp_en` is low, they load continuously.
- R9: `vevt` is high for exactly one cycle, when the counters show (0,0) after a field wrap. It does not pulse when the display is first enabled.
- R10: While `disp_en` is low, the counters are held at 0 from the next clock on. Sync, region flags and `field_odd` are low.
- R11: With `cfg_video_en` low, the counters and syncs keep running, but `border_active` and `win_active` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| disp_en | input | 1 | Run enable for the whole raster |
| cfg_totals | input | 2*CW | Field total (upper half), line total (lower half) |
| cfg_hborder | input | 2*CW | Horizontal border start (upper), stop (lower) |
| cfg_vborder | input | 2*CW | Vertical border start (upper), stop (lower) |
| cfg_hwin | input | CW | Horizontal window start |
| cfg_vwin | input | 2*CW | Window start line, long field (upper) and short field (lower) |
| cfg_video_en | input | 1 | Enables the region flags |
| cfg_interlace | input | 1 | Alternating long/short fields |
| cfg_dblscan | input | 1 | Repeat each source row on two lines |
| cfg_blank | input | 1 | Border over the whole raster |
| h_cnt | output | CW | Horizontal position |
| v_cnt | output | CW | Vertical position in the field |
| hsync | output | 1 | Horizontal sync pulse |
| vsync | output | 1 | Vertical sync pulse |
| border_active | output | 1 | Show border colour |
| win_active | output | 1 | Show window pixel data |
| win_row | output | CW | Source row inside the window |
| field_odd | output | 1 | 1 during the short field |
| vevt | output | 1 | One-cycle pulse at the start of each field |

## Verification
The hardest state to reach is a configuration change that lands in the middle of a running field. The old line length must then persist until the wrap, and the new one must appear on the very first line of the next field. The stimulus enables a known mode, rewrites the totals partway through the first field, and probes positions on either side of the boundary. Interlace needs the second and third fields to be visible. Those probes sit more than one long field after the enable, so the long extra line, the short-field window start and the return to field 0 are all observed.

// File: rtl/rtg_pkg.sv
package rtg_pkg;

   // Field identity for interlaced scanning
   typedef enum logic {
      FLD_LONG  = 1'b0,
      FLD_SHORT = 1'b1
   } field_e;

   // Mode flags that travel with the shadowed timing words
   typedef struct packed {
      logic vid;
      logic ilace;
      logic dbl;
      logic blank;
   } mode_flags_t;

endpackage

// File: rtl/rtg_cfg_latch.sv
module rtg_cfg_latch #(
   parameter int CW = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 load,
   input  logic [2*CW-1:0]      in_totals,
   input  logic [2*CW-1:0]      in_hborder,
   input  logic [2*CW-1:0]      in_vborder,
   input  logic [CW-1:0]        in_hwin,
   input  logic [2*CW-1:0]      in_vwin,
   input  rtg_pkg::mode_flags_t in_flags,
   output logic [CW-1:0]        ht,
   output logic [CW-1:0]        vt,
   output logic [CW-1:0]        hb_start,
   output logic [CW-1:0]        hb_stop,
   output logic [CW-1:0]        vb_start,
   output logic [CW-1:0]        vb_stop,
   output logic [CW-1:0]        hwin,
   output logic [CW-1:0]        vwin_long,
   output logic [CW-1:0]        vwin_short,
   output rtg_pkg::mode_flags_t flags
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ht         <= '0;
         vt         <= '0;
         hb_start   <= '0;
         hb_stop    <= '0;
         vb_start   <= '0;
         vb_stop    <= '0;
         hwin       <= '0;
         vwin_long  <= '0;
         vwin_short <= '0;
         flags      <= '0;
      end else if (load) begin
         vt         <= in_totals[2*CW-1:CW];
         ht         <= in_totals[CW-1:0];
         hb_start   <= in_hborder[2*CW-1:CW];
         hb_stop    <= in_hborder[CW-1:0];
         vb_start   <= in_vborder[2*CW-1:CW];
         vb_stop    <= in_vborder[CW-1:0];
         hwin       <= in_hwin;
         vwin_long  <= in_vwin[2*CW-1:CW];
         vwin_short <= in_vwin[CW-1:0];
         flags      <= in_flags;
      end
   end

endmodule

// File: rtl/rtg_counters.sv
module rtg_counters #(
   parameter int CW = 16
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           run,
   input  logic [CW-1:0]  ht,
   input  logic [CW-1:0]  vt,
   input  logic           ilace,
   output logic [CW-1:0]  h,
   output logic [CW-1:0]  v,
   output rtg_pkg::field_e field,
   output logic           at_last,
   output logic           vevt
);
   import rtg_pkg::*;

   localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

   logic [CW-1:0] v_end;
   logic          h_last;
   logic          v_last;

   // long field of an interlaced pair carries one extra line
   assign v_end   = (ilace && field == FLD_LONG) ? vt : vt - ONE;
   assign h_last  = (h == ht - ONE);
   assign v_last  = (v == v_end);
   assign at_last = h_last && v_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         h     <= '0;
         v     <= '0;
         field <= FLD_LONG;
         vevt  <= 1'b0;
      end else if (!run) begin
         h     <= '0;
         v     <= '0;
         field <= FLD_LONG;
         vevt  <= 1'b0;
      end else begin
         vevt <= at_last;
         if (h_last) begin
            h <= '0;
            if (v_last) begin
               v     <= '0;
               field <= (ilace && field == FLD_LONG) ? FLD_SHORT : FLD_LONG;
            end else begin
               v <= v + ONE;
            end
         end else begin
            h <= h + ONE;
         end
      end
   end

endmodule

// File: rtl/rtg_region.sv
module rtg_region #(
   parameter int CW        = 16,
   parameter int HSYNC_W   = 64,
   parameter int VSYNC_L   = 3,
   parameter bit SYNC_HIGH = 1'b1
) (
   input  logic                 run,
   input  logic [CW-1:0]        h,
   input  logic [CW-1:0]        v,
   input  rtg_pkg::field_e      field,
   input  logic [CW-1:0]        hb_start,
   input  logic [CW-1:0]        hb_stop,
   input  logic [CW-1:0]        vb_start,
   input  logic [CW-1:0]        vb_stop,
   input  logic [CW-1:0]        hwin,
   input  logic [CW-1:0]        vwin_long,
   input  logic [CW-1:0]        vwin_short,
   input  rtg_pkg::mode_flags_t flags,
   output logic                 hsync,
   output logic                 vsync,
   output logic                 border_active,
   output logic                 win_active,
   output logic [CW-1:0]        win_row
);
   import rtg_pkg::*;

   localparam logic [CW-1:0] HS_W = CW'(HSYNC_W);
   localparam logic [CW-1:0] VS_L = CW'(VSYNC_L);

   logic          hs_raw, vs_raw;
   logic          h_in, v_in, h_win, v_win;
   logic [CW-1:0] vwin_cur;
   logic [CW-1:0] dv;

   assign hs_raw   = run && (h < HS_W);
   assign vs_raw   = run && (v < VS_L);

   assign vwin_cur = (field == FLD_SHORT) ? vwin_short : vwin_long;
   assign h_in     = (h >= hb_start) && (h < hb_stop);
   assign v_in     = (v >= vb_start) && (v < vb_stop);
   assign h_win    = h_in && (h >= hwin);
   assign v_win    = v_in && (v >= vwin_cur);

   assign border_active = run && flags.vid && (flags.blank || !(h_in && v_in));
   assign win_active    = run && flags.vid && !flags.blank && h_win && v_win;

   assign dv      = v - vwin_cur;
   assign win_row = !win_active ? '0 : (flags.dbl ? (dv >> 1) : dv);

   generate
      if (SYNC_HIGH) begin : g_sync_pos
         assign hsync = hs_raw;
         assign vsync = vs_raw;
      end else begin : g_sync_neg
         assign hsync = ~hs_raw;
         assign vsync = ~vs_raw;
      end
   endgenerate

endmodule

// File: rtl/rtg_raster_top.sv
module rtg_raster_top #(
   parameter int CW        = 16,
   parameter int HSYNC_W   = 64,
   parameter int VSYNC_L   = 3,
   parameter bit SYNC_HIGH = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            disp_en,
   input  logic [2*CW-1:0] cfg_totals,
   input  logic [2*CW-1:0] cfg_hborder,
   input  logic [2*CW-1:0] cfg_vborder,
   input  logic [CW-1:0]   cfg_hwin,
   input  logic [2*CW-1:0] cfg_vwin,
   input  logic            cfg_video_en,
   input  logic            cfg_interlace,
   input  logic            cfg_dblscan,
   input  logic            cfg_blank,
   output logic [CW-1:0]   h_cnt,
   output logic [CW-1:0]   v_cnt,
   output logic            hsync,
   output logic            vsync,
   output logic            border_active,
   output logic            win_active,
   output logic [CW-1:0]   win_row,
   output logic            field_odd,
   output logic            vevt
);
   import rtg_pkg::*;

   generate
      if (CW < 8 || CW > 16) begin : g_bad_cw
         $error("rtg_raster_top: CW must lie in 8..16");
      end
      if (HSYNC_W < 1 || HSYNC_W >= (1 << CW)) begin : g_bad_hs
         $error("rtg_raster_top: HSYNC_W out of range");
      end
      if (VSYNC_L < 1 || VSYNC_L >= (1 << CW)) begin : g_bad_vs
         $error("rtg_raster_top: VSYNC_L out of range");
      end
   endgenerate

   mode_flags_t   in_flags, flags;
   logic [CW-1:0] ht, vt, hb_start, hb_stop, vb_start, vb_stop;
   logic [CW-1:0] hwin, vwin_long, vwin_short;
   logic          at_last;
   logic          load;
   field_e        field;

   assign in_flags = '{vid: cfg_video_en, ilace: cfg_interlace,
                       dbl: cfg_dblscan, blank: cfg_blank};
   assign load     = !disp_en || at_last;

   rtg_cfg_latch #(.CW(CW)) cfg_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (load),
      .in_totals  (cfg_totals),
      .in_hborder (cfg_hborder),
      .in_vborder (cfg_vborder),
      .in_hwin    (cfg_hwin),
      .in_vwin    (cfg_vwin),
      .in_flags   (in_flags),
      .ht         (ht),
      .vt         (vt),
      .hb_start   (hb_start),
      .hb_stop    (hb_stop),
      .vb_start   (vb_start),
      .vb_stop    (vb_stop),
      .hwin       (hwin),
      .vwin_long  (vwin_long),
      .vwin_short (vwin_short),
      .flags      (flags)
   );

   rtg_counters #(.CW(CW)) cnt_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (disp_en),
      .ht      (ht),
      .vt      (vt),
      .ilace   (flags.ilace),
      .h       (h_cnt),
      .v       (v_cnt),
      .field   (field),
      .at_last (at_last),
      .vevt    (vevt)
   );

   rtg_region #(
      .CW        (CW),
      .HSYNC_W   (HSYNC_W),
      .VSYNC_L   (VSYNC_L),
      .SYNC_HIGH (SYNC_HIGH)
   ) reg_i (
      .run           (disp_en),
      .h             (h_cnt),
      .v             (v_cnt),
      .field         (field),
      .hb_start      (hb_start),
      .hb_stop       (hb_stop),
      .vb_start      (vb_start),
      .vb_stop       (vb_stop),
      .hwin          (hwin),
      .vwin_long     (vwin_long),
      .vwin_short    (vwin_short),
      .flags         (flags),
      .hsync         (hsync),
      .vsync         (vsync),
      .border_active (border_active),
      .win_active    (win_active),
      .win_row       (win_row)
   );

   assign field_odd = (field == FLD_SHORT);

endmodule

// File: rtl/rtg_raster_chk.sv
module rtg_raster_chk #(
   parameter int CW        = 16,
   parameter int HSYNC_W   = 64,
   parameter bit SYNC_HIGH = 1'b1
) (
   input logic          clk,
   input logic          rst_n,
   input logic          disp_en,
   input logic [CW-1:0] h_cnt,
   input logic [CW-1:0] v_cnt,
   input logic          hsync,
   input logic          vsync,
   input logic          border_active,
   input logic          win_active,
   input logic          field_odd,
   input logic          vevt
);

   localparam logic [CW-1:0] HS_W = CW'(HSYNC_W);

   logic hs_on, vs_on;
   assign hs_on = SYNC_HIGH ? hsync : ~hsync;
   assign vs_on = SYNC_HIGH ? vsync : ~vsync;

   // R1
   h_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(disp_en) && h_cnt != '0) |-> (h_cnt == $past(h_cnt) + 1'b1));

   // R1
   v_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(disp_en) && h_cnt != '0) |-> $stable(v_cnt));

   // R2
   hsync_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hs_on |-> (h_cnt < HS_W));

   // R4
   region_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({border_active, win_active}));

   // R6
   field_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(disp_en) && !$stable(field_odd)) |-> vevt);

   // R9
   vevt_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vevt |-> (h_cnt == '0 && v_cnt == '0));

   // R10
   idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(disp_en) |-> (h_cnt == '0 && v_cnt == '0 && !field_odd));

   // R10
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !disp_en |-> (!hs_on && !vs_on && !border_active && !win_active));

endmodule

bind rtg_raster_top rtg_raster_chk #(
   .CW        (CW),
   .HSYNC_W   (HSYNC_W),
   .SYNC_HIGH (SYNC_HIGH)
) chk_i (
   .clk           (clk),
   .rst_n         (rst_n),
   .disp_en       (disp_en),
   .h_cnt         (h_cnt),
   .v_cnt         (v_cnt),
   .hsync         (hsync),
   .vsync         (vsync),
   .border_active (border_active),
   .win_active    (win_active),
   .field_odd     (field_odd),
   .vevt          (vevt)
);

// File: tb/rtg_raster_tb.sv
module rtg_raster_top_tb_top;

   localparam int CW = 16;

   typedef struct packed {
      logic       vid, il, dbl, bl;
      logic [11:0] k;
      logic [7:0] eh, ev;
      logic       ef, hs, vs, bd, win;
      logic [7:0] row;
   } vec_t;

   // base mode: 20 clocks x 12 lines, border h[4,18) v[2,11), window h>=6, v>=3 / 4
   localparam vec_t TAB [15] = '{
      '{1'b1,1'b0,1'b0,1'b0,12'd0,  8'd0, 8'd0, 1'b0,1'b1,1'b1,1'b1,1'b0,8'd0},
      '{1'b1,1'b0,1'b0,1'b0,12'd110,8'd10,8'd5, 1'b0,1'b0,1'b0,1'b0,1'b1,8'd2},
      '{1'b1,1'b0,1'b0,1'b0,12'd105,8'd5, 8'd5, 1'b0,1'b0,1'b0,1'b0,1'b0,8'd0},
      '{1'b1,1'b0,1'b0,1'b0,12'd230,8'd10,8'd11,1'b0,1'b0,1'b0,1'b1,1'b0,8'd0},
      '{1'b1,1'b0,1'b0,1'b0,12'd307,8'd7, 8'd3, 1'b0,1'b0,1'b0,1'b0,1'b1,8'd0},
      '{1'b1,1'b0,1'b1,1'b0,12'd166,8'd6, 8'd8, 1'b0,1'b0,1'b0,1'b0,1'b1,8'd2},
      '{1'b1,1'b0,1'b0,1'b1,12'd110,8'd10,8'd5, 1'b0,1'b0,1'b0,1'b1,1'b0,8'd0},
      '{1'b1,1'b1,1'b0,1'b0,12'd250,8'd10,8'd12,1'b0,1'b0,1'b0,1'b1,1'b0,8'd0},
      '{1'b1,1'b1,1'b0,1'b0,12'd330,8'd10,8'd3, 1'b1,1'b0,1'b0,1'b0,1'b0,8'd0},
      '{1'b1,1'b1,1'b0,1'b0,12'd350,8'd10,8'd4, 1'b1,1'b0,1'b0,1'b0,1'b1,8'd0},
      '{1'b1,1'b1,1'b0,1'b0,12'd520,8'd0, 8'd1, 1'b0,1'b1,1'b1,1'b1,1'b0,8'd0},
      '{1'b1,1'b0,1'b0,1'b0,12'd19, 8'd19,8'd0, 1'b0,1'b0,1'b1,1'b1,1'b0,8'd0},
      '{1'b1,1'b0,1'b0,1'b0,12'd44, 8'd4, 8'd2, 1'b0,1'b0,1'b0,1'b0,1'b0,8'd0},
      '{1'b1,1'b0,1'b0,1'b0,12'd217,8'd17,8'd10,1'b0,1'b0,1'b0,1'b0,1'b1,8'd7},
      '{1'b0,1'b0,1'b0,1'b0,12'd0,  8'd0, 8'd0, 1'b0,1'b1,1'b1,1'b0,1'b0,8'd0}
   };

   function automatic string tag_of(input int i);
      case (i)
         0:       return "R1/R2/R3 origin";
         1, 13:   return "R4 window row";
         2, 12:   return "R4 gap before window";
         3, 11:   return "R3 border outside";
         4:       return "R1 next field";
         5:       return "R7 doublescan row";
         6:       return "R5 blank";
         7, 8, 9, 10: return "R6 interlace";
         default: return "R11 video off";
      endcase
   endfunction

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            disp_en = 1'b0;
   logic [2*CW-1:0] cfg_totals  = {16'd12, 16'd20};
   logic [2*CW-1:0] cfg_hborder = {16'd4, 16'd18};
   logic [2*CW-1:0] cfg_vborder = {16'd2, 16'd11};
   logic [CW-1:0]   cfg_hwin    = 16'd6;
   logic [2*CW-1:0] cfg_vwin    = {16'd3, 16'd4};
   logic            cfg_video_en = 1'b1;
   logic            cfg_interlace = 1'b0;
   logic            cfg_dblscan = 1'b0;
   logic            cfg_blank = 1'b0;
   logic [CW-1:0]   h_cnt, v_cnt, win_row;
   logic            hsync, vsync, border_active, win_active, field_odd, vevt;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   rtg_raster_top #(.CW(CW), .HSYNC_W(3), .VSYNC_L(2)) dut_i (
      .clk (clk), .rst_n (rst_n), .disp_en (disp_en),
      .cfg_totals (cfg_totals), .cfg_hborder (cfg_hborder),
      .cfg_vborder (cfg_vborder), .cfg_hwin (cfg_hwin), .cfg_vwin (cfg_vwin),
      .cfg_video_en (cfg_video_en), .cfg_interlace (cfg_interlace),
      .cfg_dblscan (cfg_dblscan), .cfg_blank (cfg_blank),
      .h_cnt (h_cnt), .v_cnt (v_cnt), .hsync (hsync), .vsync (vsync),
      .border_active (border_active), .win_active (win_active),
      .win_row (win_row), .field_odd (field_odd), .vevt (vevt)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] snap();
      return {3'b0, h_cnt[7:0], v_cnt[7:0], field_odd, hsync, vsync,
              border_active, win_active, win_row[7:0]};
   endfunction

   // stop, load mode while idle, restart at a negedge
   task automatic restart(input logic vid, il, dbl, bl);
      @(negedge clk);
      disp_en       = 1'b0;
      cfg_totals    = {16'd12, 16'd20};
      cfg_video_en  = vid;
      cfg_interlace = il;
      cfg_dblscan   = dbl;
      cfg_blank     = bl;
      @(negedge clk);
      @(negedge clk);
      disp_en = 1'b1;
   endtask

   task automatic advance(input int k);
      repeat (k) @(posedge clk);
      #3;
   endtask

   initial begin
      #200000;
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      // reset state, R10
      #23;
      chk("R10 reset state", snap() | {31'b0, vevt}, 32'h0);
      rst_n = 1'b1;

      for (int i = 0; i < 15; i++) begin
         restart(TAB[i].vid, TAB[i].il, TAB[i].dbl, TAB[i].bl);
         advance(int'(TAB[i].k));
         chk(tag_of(i), snap(),
             {3'b0, TAB[i].eh, TAB[i].ev, TAB[i].ef, TAB[i].hs, TAB[i].vs,
              TAB[i].bd, TAB[i].win, TAB[i].row});
      end

      // R9: field event only after a wrap, one cycle wide
      restart(1'b1, 1'b0, 1'b0, 1'b0);
      advance(0);
      chk("R9 no pulse on enable", {31'b0, vevt}, 32'h0);
      advance(239);
      chk("R9 last clock of field", {15'b0, vevt, h_cnt[7:0], v_cnt[7:0]}, {15'b0, 1'b0, 8'd19, 8'd11});
      advance(1);
      chk("R9 pulse at field start", {15'b0, vevt, h_cnt[7:0], v_cnt[7:0]}, {15'b0, 1'b1, 8'd0, 8'd0});
      advance(1);
      chk("R9 pulse single cycle", {31'b0, vevt}, 32'h0);

      // R8: mid-field change of line total waits for the boundary
      restart(1'b1, 1'b0, 1'b0, 1'b0);
      advance(50);
      cfg_totals = {16'd12, 16'd10};
      advance(9);
      chk("R8 old line length kept", {16'b0, h_cnt[7:0], v_cnt[7:0]}, {16'b0, 8'd19, 8'd2});
      advance(181);
      chk("R8 boundary reached", {16'b0, h_cnt[7:0], v_cnt[7:0]}, {16'b0, 8'd0, 8'd0});
      advance(10);
      chk("R8 new line length live", {16'b0, h_cnt[7:0], v_cnt[7:0]}, {16'b0, 8'd0, 8'd1});

      // R10: dropping enable clears counters and quiets outputs
      advance(27);
      @(negedge clk);
      disp_en = 1'b0;
      advance(1);
      chk("R10 disabled", snap() | {31'b0, vevt}, 32'h0);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule